// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address. It reads a radix tree of translation tables held in memory. A requester presents a virtual address together with the value of the root table register, which holds the physical page of the top-level table. The walker then reads one table entry per level through a plain request/response memory port. Each entry it fetches supplies the page base of the next table. When it reaches the leaf, it joins the leaf's page frame with the untranslated page offset.

Each walk ends with a one-cycle completion pulse. The pulse carries the physical address, the low flag bits and no-execute bit of the last entry read, a fault indication, and the level of that entry. An entry whose present bit (bit 0) is clear stops the walk at once, and that includes an all-zero entry. The block is built for a wider memory-management unit, so caching, large pages and permission policy are left to other logic.

A build parameter picks one of two modes. The default mode walks four levels of 64-bit entries. The other mode walks two levels of 32-bit entries.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1 while `mem_req_valid` and `done_valid` are 0. A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that acceptance until the walk completes.
- R2: In the default four-level mode the walker issues one read per level, in the order level 4, 3, 2, 1. Each read goes to the table base plus the index times 8. The index comes from virtual address bits 47:39, 38:30, 29:21 and 20:12 respectively. A table base is bits 47:12 of the root value (first level) or of the previous entry, with bits 11:0 and 63:48 cleared.
- R3: Virtual address bits 63:48 change neither the read addresses nor any result.
- R4: A walk with no fault completes with `done_fault`=0, `done_level`=1 and `done_paddr` = {leaf entry bits 47:12, virtual address bits 11:0}.
- R5: `done_flags` equals bits 11:0 of the last entry read. `done_nx` equals its bit 63.
- R6: An entry whose bit 0 is clear, including an all-zero entry, ends the walk. The walk completes with `done_fault`=1 and `done_level` giving that entry's level as a binary number (4, 3, 2 or 1). No further read is issued.
- R7: `done_valid` is 1 for exactly one cycle per walk, and `req_ready` is 1 in the cycle after it.
- R8: At most one read is outstanding. `mem_req_valid` is a single-cycle pulse per level, and the next level's read follows only after `mem_rsp_valid` has returned the previous entry.
- R9: With `TWO_LEVEL`=1 the walker reads two levels, reported as levels 2 and 1. The indexes come from virtual address bits 31:22 and 21:12, and the entry stride is 4 bytes. Entries are bits 31:0 of `mem_rsp_data`, page bases are bits 31:12, `done_paddr` is 32 bits {leaf bits 31:12, offset}, and `done_nx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root table register value (physical page of top table) |
| mem_req_valid | output | 1 | One-cycle read request for a table entry |
| mem_req_addr | output | 64 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned this cycle |
| mem_rsp_data | input | 64 | Entry value returned by memory |
| done_valid | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_level | output | 3 | Level of the last entry read |
| done_paddr | output | 48 | Translated physical address (32 bits in two-level mode) |
| done_flags | output | 12 | Bits 11:0 of the last entry read |
| done_nx | output | 1 | No-execute bit of the last entry read |

## Verification
The hardest case to reach is a fault at one chosen inner level while every level above it is present. This has to happen with the table bases chained through random entry values, and with junk in the upper and flag bits that the walker must strip. The bench builds each walk's tables on the fly in a sparse memory model. It places present entries with random flags and random upper bits along the path the virtual address selects, then plants an all-zero or present-bit-clear entry at the targeted level. A memory response delay of random length checks that the walker waits for each entry. Replaying a walk with altered upper address bits against the same tables shows that those bits are ignored.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  localparam int OFF_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L4,
    ST_L3,
    ST_L2,
    ST_L1,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  // level number carried by a read state, 0 elsewhere
  function automatic logic [2:0] state_level(walk_state_e s);
    case (s)
      ST_L4:   return 3'd4;
      ST_L3:   return 3'd3;
      ST_L2:   return 3'd2;
      ST_L1:   return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic walk_state_e next_level_state(walk_state_e s);
    case (s)
      ST_L4:   return ST_L3;
      ST_L3:   return ST_L2;
      default: return ST_L1;
    endcase
  endfunction

  // keep bits [pa_w-1:OFF_W], clear flag bits and bits above the frame
  function automatic logic [63:0] page_base(logic [63:0] v, int pa_w);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      r[i] = (i >= OFF_W && i < pa_w) ? v[i] : 1'b0;
    end
    return r;
  endfunction

  // idx_w-bit index field for a level (level 1 sits just above the offset)
  function automatic logic [63:0] table_index(logic [63:0] va, int lvl, int idx_w);
    logic [63:0] mask;
    mask = (64'd1 << idx_w) - 64'd1;
    return (va >> (OFF_W + idx_w * (lvl - 1))) & mask;
  endfunction

  function automatic logic [63:0] entry_addr(logic [63:0] base, logic [63:0] idx,
                                             int stride_log2);
    return base + (idx << stride_log2);
  endfunction

  // restrict a raw response word to the entry width of the mode
  function automatic logic [63:0] trim_entry(logic [63:0] d, int entry_w);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      r[i] = (i < entry_w) ? d[i] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [63:0] leaf_addr(logic [63:0] ent, logic [63:0] va, int pa_w);
    return page_base(ent, pa_w) | {52'd0, va[OFF_W-1:0]};
  endfunction

endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr
  import pt_walk_pkg::*;
#(
  parameter bit TWO_LEVEL = 1'b0
) (
  input  logic [63:0] va,
  input  logic [63:0] base,
  input  logic [2:0]  level,
  output logic [63:0] ent_addr
);
  localparam int LEVELS      = TWO_LEVEL ? 2 : 4;
  localparam int IDX_W       = TWO_LEVEL ? 10 : 9;
  localparam int STRIDE_LOG2 = TWO_LEVEL ? 2 : 3;

  logic [63:0] idx_by_level [1:LEVELS];
  logic [63:0] idx_sel;

  for (genvar g = 1; g <= LEVELS; g++) begin : g_idx
    assign idx_by_level[g] = table_index(va, g, IDX_W);
  end

  always_comb begin
    idx_sel = '0;
    for (int l = 1; l <= LEVELS; l++) begin
      if (level == l[2:0]) idx_sel = idx_by_level[l];
    end
    ent_addr = entry_addr(base, idx_sel, STRIDE_LOG2);
  end
endmodule

// File: rtl/pt_walk_eval.sv
module pt_walk_eval
  import pt_walk_pkg::*;
#(
  parameter bit TWO_LEVEL = 1'b0
) (
  input  logic [63:0]     rsp_data,
  input  logic [63:0]     va,
  output logic            present,
  output logic            nx,
  output logic [OFF_W-1:0] flags,
  output logic [63:0]     next_base,
  output logic [(TWO_LEVEL ? 32 : 48)-1:0] leaf_pa
);
  localparam int ENTRY_W = TWO_LEVEL ? 32 : 64;
  localparam int PA_W    = TWO_LEVEL ? 32 : 48;

  logic [63:0] entry;

  assign entry     = trim_entry(rsp_data, ENTRY_W);
  assign present   = entry[0];
  assign flags     = entry[OFF_W-1:0];
  assign next_base = page_base(entry, PA_W);
  assign leaf_pa   = PA_W'(leaf_addr(entry, va, PA_W));

  if (TWO_LEVEL) begin : g_narrow
    assign nx = 1'b0;
  end else begin : g_wide
    assign nx = entry[63];
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
#(
  parameter bit TWO_LEVEL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [63:0]          req_vaddr,
  input  logic [63:0]          req_root,
  output logic                 mem_req_valid,
  input  logic                 mem_rsp_valid,
  output logic [63:0]          va_cur,
  output logic [63:0]          base_cur,
  output logic [2:0]           level_cur,
  input  logic                 ent_present,
  input  logic                 ent_nx,
  input  logic [OFF_W-1:0]     ent_flags,
  input  logic [63:0]          ent_next_base,
  input  logic [(TWO_LEVEL ? 32 : 48)-1:0] ent_leaf_pa,
  output logic                 done_valid,
  output logic                 done_fault,
  output logic [2:0]           done_level,
  output logic [(TWO_LEVEL ? 32 : 48)-1:0] done_paddr,
  output logic [OFF_W-1:0]     done_flags,
  output logic                 done_nx
);
  localparam int PA_W = TWO_LEVEL ? 32 : 48;
  localparam walk_state_e FIRST_ST = TWO_LEVEL ? ST_L2 : ST_L4;

  walk_state_e         state_q;
  logic                pending_q;
  logic [63:0]         va_q;
  logic [63:0]         base_q;
  logic [PA_W-1:0]     pa_q;
  logic [OFF_W-1:0]    flags_q;
  logic                nx_q;
  logic [2:0]          lvl_q;

  // named internal events
  logic in_level, rsp_take, walk_fault, leaf_hit, accept;

  assign level_cur     = state_level(state_q);
  assign in_level      = (level_cur != 3'd0);
  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = in_level && !pending_q;
  assign rsp_take      = in_level && pending_q && mem_rsp_valid;
  assign walk_fault    = rsp_take && !ent_present;
  assign leaf_hit      = rsp_take && ent_present && (level_cur == 3'd1);
  assign va_cur        = va_q;
  assign base_cur      = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pending_q <= 1'b0;
      va_q      <= '0;
      base_q    <= '0;
      pa_q      <= '0;
      flags_q   <= '0;
      nx_q      <= 1'b0;
      lvl_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q   <= FIRST_ST;
            pending_q <= 1'b0;
            va_q      <= req_vaddr;
            base_q    <= page_base(req_root, PA_W);
            pa_q      <= '0;
          end
        end
        ST_DONE, ST_FAULT: begin
          state_q <= ST_IDLE;
        end
        default: begin
          if (mem_req_valid) pending_q <= 1'b1;
          if (rsp_take) begin
            pending_q <= 1'b0;
            flags_q   <= ent_flags;
            nx_q      <= ent_nx;
            lvl_q     <= level_cur;
            if (walk_fault) begin
              state_q <= ST_FAULT;
            end else if (leaf_hit) begin
              pa_q    <= ent_leaf_pa;
              state_q <= ST_DONE;
            end else begin
              base_q  <= ent_next_base;
              state_q <= next_level_state(state_q);
            end
          end
        end
      endcase
    end
  end

  assign done_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign done_fault = (state_q == ST_FAULT);
  assign done_level = lvl_q;
  assign done_paddr = pa_q;
  assign done_flags = flags_q;
  assign done_nx    = nx_q;

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!req_ready && mem_req_valid));

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  // R6
  fault_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |=> (done_valid && done_fault && !mem_req_valid));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_fault) |-> (done_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]
                                     && done_level == 3'd1));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter bit TWO_LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [63:0] req_root,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done_valid,
  output logic        done_fault,
  output logic [2:0]  done_level,
  output logic [(TWO_LEVEL ? 32 : 48)-1:0] done_paddr,
  output logic [11:0] done_flags,
  output logic        done_nx
);
  localparam int PA_W        = TWO_LEVEL ? 32 : 48;
  localparam int STRIDE_LOG2 = TWO_LEVEL ? 2 : 3;

  logic [63:0]      va_cur, base_cur, ent_next_base;
  logic [2:0]       level_cur;
  logic             ent_present, ent_nx;
  logic [OFF_W-1:0] ent_flags;
  logic [PA_W-1:0]  ent_leaf_pa;

  pt_walk_addr #(.TWO_LEVEL(TWO_LEVEL)) addr_i (
    .va       (va_cur),
    .base     (base_cur),
    .level    (level_cur),
    .ent_addr (mem_req_addr)
  );

  pt_walk_eval #(.TWO_LEVEL(TWO_LEVEL)) eval_i (
    .rsp_data  (mem_rsp_data),
    .va        (va_cur),
    .present   (ent_present),
    .nx        (ent_nx),
    .flags     (ent_flags),
    .next_base (ent_next_base),
    .leaf_pa   (ent_leaf_pa)
  );

  pt_walk_ctrl #(.TWO_LEVEL(TWO_LEVEL)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_root      (req_root),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .va_cur        (va_cur),
    .base_cur      (base_cur),
    .level_cur     (level_cur),
    .ent_present   (ent_present),
    .ent_nx        (ent_nx),
    .ent_flags     (ent_flags),
    .ent_next_base (ent_next_base),
    .ent_leaf_pa   (ent_leaf_pa),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_level    (done_level),
    .done_paddr    (done_paddr),
    .done_flags    (done_flags),
    .done_nx       (done_nx)
  );

  // R2
  entry_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[STRIDE_LOG2-1:0] == '0
                       && mem_req_addr[63:PA_W] == '0));
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps

module pt_walk_mem_model (
  input  logic        clk,
  input  logic        req_v,
  input  logic [63:0] req_a,
  output logic        rsp_v,
  output logic [63:0] rsp_d
);
  logic [63:0] store [logic [63:0]];
  logic [63:0] log_a [0:7];
  int          log_n;
  int          overlap;
  logic        busy;
  logic [63:0] addr;
  int          cnt;

  initial begin
    rsp_v = 0; rsp_d = 0; busy = 0; addr = 0; cnt = 0; log_n = 0; overlap = 0;
  end

  task automatic clear();
    store.delete();
    log_n = 0;
    overlap = 0;
  endtask

  task automatic poke(input logic [63:0] a, input logic [63:0] d);
    store[a] = d;
  endtask

  function automatic logic [63:0] peek(input logic [63:0] a);
    return store.exists(a) ? store[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    rsp_v <= 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        rsp_v <= 1'b1;
        rsp_d <= peek(addr);
        busy  <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
    if (req_v) begin
      if (busy) overlap = overlap + 1;
      busy <= 1'b1;
      addr <= req_a;
      cnt  <= $urandom % 4;
      if (log_n < 8) log_a[log_n] = req_a;
      log_n = log_n + 1;
    end
  end
endmodule

module pt_walker_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // four-level instance
  logic        rv4 = 0, rdy4, mrv4, mrspv4, dv4, df4, dnx4;
  logic [63:0] va4 = 0, root4 = 0, mra4, mrspd4;
  logic [2:0]  dl4;
  logic [47:0] dpa4;
  logic [11:0] dfl4;
  // two-level instance
  logic        rv2 = 0, rdy2, mrv2, mrspv2, dv2, df2, dnx2;
  logic [63:0] va2 = 0, root2 = 0, mra2, mrspd2;
  logic [2:0]  dl2;
  logic [31:0] dpa2;
  logic [11:0] dfl2;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(rv4), .req_ready(rdy4), .req_vaddr(va4),
    .req_root(root4), .mem_req_valid(mrv4), .mem_req_addr(mra4),
    .mem_rsp_valid(mrspv4), .mem_rsp_data(mrspd4), .done_valid(dv4),
    .done_fault(df4), .done_level(dl4), .done_paddr(dpa4), .done_flags(dfl4),
    .done_nx(dnx4));

  pt_walker #(.TWO_LEVEL(1'b1)) dut2_i (
    .clk(clk), .rst_n(rst_n), .req_valid(rv2), .req_ready(rdy2), .req_vaddr(va2),
    .req_root(root2), .mem_req_valid(mrv2), .mem_req_addr(mra2),
    .mem_rsp_valid(mrspv2), .mem_rsp_data(mrspd2), .done_valid(dv2),
    .done_fault(df2), .done_level(dl2), .done_paddr(dpa2), .done_flags(dfl2),
    .done_nx(dnx2));

  pt_walk_mem_model mdl4 (.clk(clk), .req_v(mrv4), .req_a(mra4), .rsp_v(mrspv4), .rsp_d(mrspd4));
  pt_walk_mem_model mdl2 (.clk(clk), .req_v(mrv2), .req_a(mra2), .rsp_v(mrspv2), .rsp_d(mrspd2));

  // expectation of the most recent walk
  logic [63:0] exp_a [0:3];
  int          exp_n;
  logic [63:0] exp_pa;
  logic [11:0] exp_fl;
  logic        exp_nx, exp_f;
  logic [2:0]  exp_lvl;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // lay out tables along the path of va and compute the expected outcome
  task automatic build(input bit two, input logic [63:0] va, input logic [63:0] root,
                       input int fault_lvl);
    logic [63:0] pmask, base, idx, ea, ent;
    int levels, w, stride;
    bit stop;
    pmask  = two ? 64'h0000_0000_FFFF_F000 : 64'h0000_FFFF_FFFF_F000;
    levels = two ? 2 : 4;
    w      = two ? 10 : 9;
    stride = two ? 4 : 8;
    if (two) mdl2.clear(); else mdl4.clear();
    base = root & pmask;
    exp_n = 0; exp_f = 0; exp_pa = 0; stop = 0;
    for (int lvl = levels; lvl >= 1; lvl--) begin
      if (!stop) begin
        idx = (va >> (12 + w * (lvl - 1))) & ((64'd1 << w) - 1);
        ea  = base + idx * stride;
        exp_a[exp_n] = ea;
        exp_n++;
        if (lvl == fault_lvl) begin
          ent = ($urandom % 2 == 0) ? 64'd0 : (rnd64() & ~64'd1);
        end else begin
          ent = rnd64() | 64'd1;
        end
        if (two) ent = ent & 64'hFFFF_FFFF;
        if (two) mdl2.poke(ea, ent); else mdl4.poke(ea, ent);
        exp_fl  = ent[11:0];
        exp_nx  = two ? 1'b0 : ent[63];
        exp_lvl = 3'(lvl);
        if (lvl == fault_lvl) begin
          exp_f = 1; stop = 1;
        end else if (lvl == 1) begin
          exp_pa = (ent & pmask) | {52'd0, va[11:0]};
        end else begin
          base = ent & pmask;
        end
      end
    end
  endtask

  task automatic run(input bit two, input logic [63:0] va, input logic [63:0] root,
                     input string req);
    bit got, f;
    logic [2:0] l;
    logic [63:0] pa, a;
    logic [11:0] fl;
    logic nx;
    int ln, ov;
    @(negedge clk);
    if (two) begin rv2 = 1; va2 = va; root2 = root; end
    else     begin rv4 = 1; va4 = va; root4 = root; end
    chk((two ? rdy2 : rdy4) == 1'b1, "R1", "ready before request", 0, 1);
    @(negedge clk);
    rv2 = 0; rv4 = 0;
    chk((two ? rdy2 : rdy4) == 1'b0, "R1", "ready while walking", 1, 0);
    got = 0;
    for (int c = 0; c < 200 && !got; c++) begin
      if (two ? dv2 : dv4) begin
        got = 1;
        f  = two ? df2 : df4;
        l  = two ? dl2 : dl4;
        pa = two ? 64'(dpa2) : 64'(dpa4);
        fl = two ? dfl2 : dfl4;
        nx = two ? dnx2 : dnx4;
      end else begin
        @(negedge clk);
      end
    end
    if (!got) begin
      chk(0, req, "walk timed out", 0, 1);
      return;
    end
    chk(f == exp_f, exp_f ? "R6" : "R4", "fault", 64'(f), 64'(exp_f));
    chk(l == exp_lvl, exp_f ? "R6" : "R4", "level", 64'(l), 64'(exp_lvl));
    chk(fl == exp_fl, "R5", "flags", 64'(fl), 64'(exp_fl));
    chk(nx == exp_nx, "R5", "nx", 64'(nx), 64'(exp_nx));
    if (!exp_f) chk(pa == exp_pa, req, "physical address", pa, exp_pa);
    @(negedge clk);
    chk((two ? dv2 : dv4) == 1'b0, "R7", "done width", 1, 0);
    chk((two ? rdy2 : rdy4) == 1'b1, "R7", "ready after done", 0, 1);
    ln = two ? mdl2.log_n : mdl4.log_n;
    ov = two ? mdl2.overlap : mdl4.overlap;
    chk(ln == exp_n, exp_f ? "R6" : req, "read count", 64'(ln), 64'(exp_n));
    chk(ov == 0, "R8", "overlapping reads", 64'(ov), 0);
    for (int i = 0; i < exp_n && i < ln; i++) begin
      a = two ? mdl2.log_a[i] : mdl4.log_a[i];
      chk(a == exp_a[i], two ? "R9" : "R2", "entry address", a, exp_a[i]);
    end
    if (two) mdl2.log_n = 0; else mdl4.log_n = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "WATCHDOG", "run expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] va, root;
    void'($urandom(32'd4321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(rdy4 == 1 && rdy2 == 1, "R1", "ready after reset", 64'(rdy4), 1);
    chk(mrv4 == 0 && dv4 == 0, "R1", "idle outputs after reset", 64'({mrv4, dv4}), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R4 R5 directed walk
    va = 64'h0000_7f46_9ae0_5445; root = rnd64();
    build(0, va, root, 0); run(0, va, root, "R4");
    // R3 same tables, upper bits altered
    va = 64'hABCD_7f46_9ae0_5445;
    run(0, va, root, "R3");
    // R2 index extremes
    va = 64'h0000_FFFF_FFFF_FFFF; root = rnd64();
    build(0, va, root, 0); run(0, va, root, "R2");
    va = 64'hFFFF_0000_0000_0000; root = rnd64();
    build(0, va, root, 0); run(0, va, root, "R3");
    // R6 fault at every level
    for (int lv = 4; lv >= 1; lv--) begin
      va = rnd64(); root = rnd64();
      build(0, va, root, lv); run(0, va, root, "R6");
    end
    // R9 two-level directed
    va = 64'h0000_0000_9ae0_5445; root = rnd64();
    build(1, va, root, 0); run(1, va, root, "R9");
    va = 64'h1234_5678_FFFF_FFFF; root = rnd64();
    build(1, va, root, 0); run(1, va, root, "R9");
    for (int lv = 2; lv >= 1; lv--) begin
      va = rnd64(); root = rnd64();
      build(1, va, root, lv); run(1, va, root, "R9");
    end
    // random mix
    for (int k = 0; k < 40; k++) begin
      va = rnd64(); root = rnd64();
      build(0, va, root, ($urandom % 3 == 0) ? int'($urandom % 4) + 1 : 0);
      run(0, va, root, "R4");
    end
    for (int k = 0; k < 20; k++) begin
      va = rnd64(); root = rnd64();
      build(1, va, root, ($urandom % 3 == 0) ? int'($urandom % 2) + 1 : 0);
      run(1, va, root, "R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule